// File: doc/BRIEF.md
# Serpentine Contraction Access Sequencer

This block sequences every memory access needed to multiply two N×N operands, C = A·B, when the operands sit in shift-addressed storage clusters. Each cluster has one access port, and moving that port by one position costs one shift. The sequencer walks the operands in a zig-zag order that matches an alternating storage layout. Because of that order, no port on A or B is ever rewound between output elements or between output rows.

Each cycle of a contraction carries one product. On those cycles the block presents a cluster index and a port position for A and for B, together with multiply-accumulate strobes. It accumulates the products of each output entry and writes the finished entry into the C bank. After the last entry it rewinds the C clusters one shift per cycle and then raises a done pulse.

Two counters run alongside. One tallies the shifts that do useful work. The other tallies the shifts spent only on returning ports to position 0.

Top module: `scs_sequencer`

## Requirements
- R1: Cluster map. Row i of A lives in cluster i. Column j of B lives in cluster N+j. Row i of C lives in cluster 2N+i. Output entry (i,j) is written at position j of cluster 2N+i.
- R2: An output entry takes N consecutive product cycles. mac_first is high only on the first of them. Between consecutive products of one entry, both the A port and the B port move by exactly one position.
- R3: Stored layout. Element l of row i of A sits at position l when i is even and at position N-1-l when i is odd. Element l of column j of B sits at position l when j is even and at position N-1-l when j is odd. On every product cycle the A element index equals the B element index, and each entry covers all N indices.
- R4: No rewind. The first product of an entry uses the same A position as the last product of the previous entry in that row. It uses the same B positions that the previous row left behind.
- R5: Entries are produced row by row, with j ascending inside each row. c_wr rises exactly one cycle after the N-th product of an entry. At that moment c_wdata equals the full sum of the N products, because the accumulator restarts on each mac_first.
- R6: N is even, so when a contraction finishes every A and B port is back at position 0.
- R7: After the last product the block rewinds the C clusters. It does one shift per cycle with home_shift high, visiting clusters 2N to 3N-1 in order. For each cluster, home_pos (the position after the shift) steps from N-2 down to 0. No product cycle overlaps this phase, and every C port ends at 0.
- R8: At done, cnt_comp equals 2N³−N²−N and cnt_ovh equals N(N−1). Both counters clear when a new start is accepted.
- R9: done is a single-cycle pulse that appears N³+N(N−1) cycles after the start-accept edge. busy stays high from start to done. A start seen while busy has no effect.
- R10: After reset, busy, done, mac_en, c_wr and home_shift are low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a contraction when idle |
| a_rd_data | input | DW | A element read at the current A port |
| b_rd_data | input | DW | B element read at the current B port |
| a_cl | output | CL_W | A cluster index |
| a_pos | output | POS_W | A port position |
| b_cl | output | CL_W | B cluster index |
| b_pos | output | POS_W | B port position |
| mac_en | output | 1 | Product cycle |
| mac_first | output | 1 | First product of an entry |
| c_wr | output | 1 | Write C entry |
| c_cl | output | CL_W | C cluster index |
| c_pos | output | POS_W | C write position |
| c_wdata | output | ACC_W | Accumulated entry value |
| home_shift | output | 1 | One rewind shift on a C cluster |
| home_cl | output | CL_W | Cluster being rewound |
| home_pos | output | POS_W | Port position after the rewind shift |
| busy | output | 1 | Contraction in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_comp | output | CNT_W | Useful shift count |
| cnt_ovh | output | CNT_W | Rewind shift count |

## Verification
The bench builds the block with N=4 and DW=8. At that size a contraction lasts 77 cycles, so every product, write and rewind of several full contractions can be checked against a port-position model kept in the bench. Three operand patterns are used: ramps, all-ones at the top of the data range (which fills the accumulator width) and a pseudo-random fill. The four row and column parity combinations of the zig-zag, the overlap of the final write with the first rewind, and back-to-back runs that start from the ports left by the previous run are all reached.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOME,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic a_step;
        logic b_step;
        logic c_step;
        logic home_step;
    } shift_ev_t;

    function automatic int unsigned zz_pos(int unsigned idx, int unsigned n, logic flip);
        return flip ? (n - 1 - idx) : idx;
    endfunction

    function automatic int unsigned comp_total(int unsigned n);
        return 2 * n * n * n - n * n - n;
    endfunction

endpackage

// File: rtl/scs_loop_ctr.sv
module scs_loop_ctr #(
    parameter int unsigned N     = 4,
    parameter int unsigned POS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [POS_W-1:0] row,
    output logic [POS_W-1:0] col,
    output logic [POS_W-1:0] step,
    output logic             last_step,
    output logic             last_all
);
    localparam int unsigned DIGITS = 3;
    localparam logic [POS_W-1:0] TOP = POS_W'(N - 1);

    logic [DIGITS:0] carry;
    logic [DIGITS-1:0] at_top;
    assign carry[0] = advance;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [POS_W-1:0] d;
        assign at_top[g]    = (d == TOP);
        assign carry[g + 1] = carry[g] & at_top[g];
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                d <= '0;
            end else if (carry[g]) begin
                d <= at_top[g] ? '0 : d + 1'b1;
            end
        end
    end

    assign step      = g_dig[0].d;
    assign col       = g_dig[1].d;
    assign row       = g_dig[2].d;
    assign last_step = at_top[0];
    assign last_all  = &at_top;

endmodule

// File: rtl/scs_addr_gen.sv
module scs_addr_gen
    import scs_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned POS_W = 2,
    parameter int unsigned CL_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [POS_W-1:0] row,
    input  logic [POS_W-1:0] col,
    input  logic [POS_W-1:0] step,
    output logic [CL_W-1:0]  a_cl,
    output logic [POS_W-1:0] a_pos,
    output logic [CL_W-1:0]  b_cl,
    output logic [POS_W-1:0] b_pos
);
    // A walks its row backwards on odd columns, B walks its column backwards on odd rows
    always_comb begin
        a_cl  = CL_W'(row);
        b_cl  = CL_W'(N) + CL_W'(col);
        a_pos = POS_W'(zz_pos(int'(step), N, col[0]));
        b_pos = POS_W'(zz_pos(int'(step), N, row[0]));
    end

    // element index seen through each stored layout must agree
    AST_LOGICAL_PAIR: assert property (@(posedge clk) disable iff (rst)
        en |-> (zz_pos(int'(a_pos), N, a_cl[0]) ==
                zz_pos(int'(b_pos), N, col[0]))) else $error("pair"); // R3

endmodule

// File: rtl/scs_shift_tally.sv
module scs_shift_tally
    import scs_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  shift_ev_t        ev,
    output logic [CNT_W-1:0] cnt_comp,
    output logic [CNT_W-1:0] cnt_ovh
);
    logic [CNT_W-1:0] comp_inc;
    assign comp_inc = CNT_W'(ev.a_step) + CNT_W'(ev.b_step) + CNT_W'(ev.c_step);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_comp <= '0;
            cnt_ovh  <= '0;
        end else begin
            cnt_comp <= cnt_comp + comp_inc;
            cnt_ovh  <= cnt_ovh + CNT_W'(ev.home_step);
        end
    end

endmodule

// File: rtl/scs_sequencer.sv
module scs_sequencer
    import scs_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 8,
    localparam int unsigned POS_W = $clog2(N),
    localparam int unsigned CL_W  = $clog2(3 * N),
    localparam int unsigned ACC_W = 2 * DW + $clog2(N),
    localparam int unsigned CNT_W = $clog2(2 * N * N * N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    a_rd_data,
    input  logic [DW-1:0]    b_rd_data,
    output logic [CL_W-1:0]  a_cl,
    output logic [POS_W-1:0] a_pos,
    output logic [CL_W-1:0]  b_cl,
    output logic [POS_W-1:0] b_pos,
    output logic             mac_en,
    output logic             mac_first,
    output logic             c_wr,
    output logic [CL_W-1:0]  c_cl,
    output logic [POS_W-1:0] c_pos,
    output logic [ACC_W-1:0] c_wdata,
    output logic             home_shift,
    output logic [CL_W-1:0]  home_cl,
    output logic [POS_W-1:0] home_pos,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt_comp,
    output logic [CNT_W-1:0] cnt_ovh
);
    localparam logic [POS_W-1:0] TOP      = POS_W'(N - 1);
    localparam logic [POS_W-1:0] HOME_TOP = POS_W'(N - 2);
    localparam logic [CNT_W-1:0] COMP_TOT = CNT_W'(comp_total(N));
    localparam logic [CNT_W-1:0] OVH_TOT  = CNT_W'(N * (N - 1));

    seq_state_t st;
    logic [POS_W-1:0] li, lj, lk;
    logic last_k, last_all, run, accept;
    logic [POS_W-1:0] hr, hs;
    logic [ACC_W-1:0] acc, prod;
    shift_ev_t ev;

    assign run    = (st == ST_RUN);
    assign accept = (st == ST_IDLE) && start;

    scs_loop_ctr #(.N(N), .POS_W(POS_W)) i_loop (
        .clk(clk), .rst(rst), .clear(accept), .advance(run),
        .row(li), .col(lj), .step(lk),
        .last_step(last_k), .last_all(last_all)
    );

    scs_addr_gen #(.N(N), .POS_W(POS_W), .CL_W(CL_W)) i_addr (
        .clk(clk), .rst(rst), .en(run),
        .row(li), .col(lj), .step(lk),
        .a_cl(a_cl), .a_pos(a_pos), .b_cl(b_cl), .b_pos(b_pos)
    );

    // phase control
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (start) st <= ST_RUN;
                ST_RUN:  if (last_all) st <= ST_HOME;
                ST_HOME: if (hr == TOP && hs == '0) st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // rewind walk over the C bank, one shift per cycle
    always_ff @(posedge clk) begin
        if (rst || st != ST_HOME) begin
            hr <= '0;
            hs <= HOME_TOP;
        end else if (hs == '0) begin
            hr <= hr + 1'b1;
            hs <= HOME_TOP;
        end else begin
            hs <= hs - 1'b1;
        end
    end

    // accumulator restarts on the first product of every entry
    assign prod = ACC_W'(a_rd_data) * ACC_W'(b_rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            c_wr   <= 1'b0;
            c_cl   <= '0;
            c_pos  <= '0;
        end else begin
            if (run) acc <= (lk == '0) ? prod : acc + prod;
            c_wr  <= run && last_k;
            c_cl  <= CL_W'(2 * N) + CL_W'(li);
            c_pos <= lj;
        end
    end

    assign c_wdata    = acc;
    assign mac_en     = run;
    assign mac_first  = run && (lk == '0);
    assign home_shift = (st == ST_HOME);
    assign home_cl    = CL_W'(2 * N) + CL_W'(hr);
    assign home_pos   = hs;
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);

    always_comb begin
        ev.a_step    = mac_en && !mac_first;
        ev.b_step    = mac_en && !mac_first;
        ev.c_step    = c_wr && (c_pos != '0);
        ev.home_step = home_shift;
    end

    scs_shift_tally #(.CNT_W(CNT_W)) i_tally (
        .clk(clk), .rst(rst), .clear(accept), .ev(ev),
        .cnt_comp(cnt_comp), .cnt_ovh(cnt_ovh)
    );

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (mac_en && !mac_first) |->
            ((int'(a_pos) - int'($past(a_pos)) == 1 || int'($past(a_pos)) - int'(a_pos) == 1) &&
             (int'(b_pos) - int'($past(b_pos)) == 1 || int'($past(b_pos)) - int'(b_pos) == 1)))
        else $error("step"); // R2
    AST_NO_REWIND: assert property (@(posedge clk) disable iff (rst)
        (mac_first && $past(mac_en) && a_cl == $past(a_cl)) |-> a_pos == $past(a_pos))
        else $error("rewind"); // R4
    AST_CWR_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        c_wr |-> $past(mac_en)) else $error("cwr"); // R5
    AST_HOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        home_shift |-> !mac_en) else $error("home"); // R7
    AST_TOTALS: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_comp == COMP_TOT && cnt_ovh == OVH_TOT)) else $error("totals"); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done"); // R9

endmodule

// File: tb/test_scs_sequencer.sv
module test_scs_sequencer;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int POS_W = $clog2(N);
    localparam int CL_W  = $clog2(3 * N);
    localparam int ACC_W = 2 * DW + $clog2(N);
    localparam int CNT_W = $clog2(2 * N * N * N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DW-1:0] a_rd_data, b_rd_data;
    logic [CL_W-1:0] a_cl, b_cl, c_cl, home_cl;
    logic [POS_W-1:0] a_pos, b_pos, c_pos, home_pos;
    logic mac_en, mac_first, c_wr, home_shift, busy, done;
    logic [ACC_W-1:0] c_wdata;
    logic [CNT_W-1:0] cnt_comp, cnt_ovh;

    always #10 clk = ~clk;

    scs_sequencer #(.N(N), .DW(DW)) i_scs_sequencer (
        .clk(clk), .rst(rst), .start(start),
        .a_rd_data(a_rd_data), .b_rd_data(b_rd_data),
        .a_cl(a_cl), .a_pos(a_pos), .b_cl(b_cl), .b_pos(b_pos),
        .mac_en(mac_en), .mac_first(mac_first),
        .c_wr(c_wr), .c_cl(c_cl), .c_pos(c_pos), .c_wdata(c_wdata),
        .home_shift(home_shift), .home_cl(home_cl), .home_pos(home_pos),
        .busy(busy), .done(done), .cnt_comp(cnt_comp), .cnt_ovh(cnt_ovh)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] amat [N][N];
    logic [DW-1:0] bmat [N][N];
    int port [3*N];
    int shifts_c, shifts_o, mac_ent, pcount, wr_ent, home_idx, done_cnt;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // element index stored at a position, per the alternating layout of R3
    function automatic int lidx(input int owner, input int pos);
        return (owner % 2 == 1) ? (N - 1 - pos) : pos;
    endfunction

    function automatic logic [DW-1:0] rd_a(input int cl, input int pos);
        if (cl < 0 || cl >= N) return '0;
        return amat[cl][lidx(cl, pos)];
    endfunction

    function automatic logic [DW-1:0] rd_b(input int cl, input int pos);
        int j;
        j = cl - N;
        if (j < 0 || j >= N) return '0;
        return bmat[lidx(j, pos)][j];
    endfunction

    function automatic longint exp_c(input int i, input int j);
        longint s;
        s = 0;
        for (int l = 0; l < N; l++) s += longint'(amat[i][l]) * longint'(bmat[l][j]);
        return s;
    endfunction

    assign a_rd_data = rd_a(int'(a_cl), int'(a_pos));
    assign b_rd_data = rd_b(int'(b_cl), int'(b_pos));

    // observer: port model and per-cycle checks
    always @(negedge clk) begin
        if (!rst) begin
            if (c_wr) begin
                int d;
                d = iabs(int'(c_pos) - port[c_cl]);
                check(pcount == N, "R5 products before write", pcount, N);
                check(int'(c_cl) == 2*N + wr_ent/N, "R1 c cluster", c_cl, 2*N + wr_ent/N);
                check(int'(c_pos) == wr_ent % N, "R1 c position", c_pos, wr_ent % N);
                check(longint'(c_wdata) == exp_c(wr_ent/N, wr_ent%N), "R5 entry value",
                      c_wdata, exp_c(wr_ent/N, wr_ent%N));
                check(d <= 1, "R2 c step", d, 1);
                shifts_c += d;
                port[c_cl] = int'(c_pos);
                wr_ent++;
            end
            if (mac_en) begin
                int da, db, la, lb;
                da = iabs(int'(a_pos) - port[a_cl]);
                db = iabs(int'(b_pos) - port[b_cl]);
                la = lidx(int'(a_cl), int'(a_pos));
                lb = lidx(int'(b_cl) - N, int'(b_pos));
                check(la == lb, "R3 index pairing", la, lb);
                if (mac_first) begin
                    mac_ent++;
                    pcount = 1;
                    check(int'(a_cl) == mac_ent/N, "R1 a cluster", a_cl, mac_ent/N);
                    check(int'(b_cl) == N + mac_ent%N, "R1 b cluster", b_cl, N + mac_ent%N);
                    check(da == 0 && db == 0, "R4 no rewind", da + db, 0);
                end else begin
                    pcount++;
                    check(da == 1 && db == 1, "R2 unit step", da + db, 2);
                end
                shifts_c += da + db;
                port[a_cl] = int'(a_pos);
                port[b_cl] = int'(b_pos);
            end
            if (home_shift) begin
                int d, ecl, epos;
                ecl  = 2*N + home_idx/(N-1);
                epos = N - 2 - home_idx%(N-1);
                d = iabs(int'(home_pos) - port[home_cl]);
                check(!mac_en, "R7 no product in rewind", mac_en, 0);
                check(int'(home_cl) == ecl && int'(home_pos) == epos, "R7 rewind order",
                      int'(home_cl)*100 + int'(home_pos), ecl*100 + epos);
                check(d == 1, "R7 rewind step", d, 1);
                shifts_o += d;
                port[home_cl] = int'(home_pos);
                home_idx++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic run_one(input bit poke);
        int cyc;
        shifts_c = 0; shifts_o = 0; mac_ent = -1; pcount = 0;
        wr_ent = 0; home_idx = 0; done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            if (cyc == 1) check(cnt_comp == 0 && cnt_ovh == 0, "R8 counters cleared",
                                cnt_comp + cnt_ovh, 0);
            if (poke && cyc == 30) start = 1'b1;
            if (poke && cyc == 31) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(cyc == N*N*N + N*(N-1) + 1, "R9 run length", cyc, N*N*N + N*(N-1) + 1);
        check(wr_ent == N*N, "R5 entry count", wr_ent, N*N);
        check(home_idx == N*(N-1), "R7 rewind count", home_idx, N*(N-1));
        for (int c = 0; c < 2*N; c++) check(port[c] == 0, "R6 port home", port[c], 0);
        for (int c = 2*N; c < 3*N; c++) check(port[c] == 0, "R7 c port home", port[c], 0);
        check(int'(cnt_comp) == 2*N*N*N - N*N - N, "R8 useful count", cnt_comp, 2*N*N*N - N*N - N);
        check(shifts_c == 2*N*N*N - N*N - N, "R8 modelled useful shifts", shifts_c, 2*N*N*N - N*N - N);
        check(int'(cnt_ovh) == N*(N-1), "R8 rewind count", cnt_ovh, N*(N-1));
        check(shifts_o == N*(N-1), "R8 modelled rewind shifts", shifts_o, N*(N-1));
        @(negedge clk);
        check(!done && !busy, "R9 done pulse ends", done + busy, 0);
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3*N; c++) port[c] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mac_en && !c_wr && !home_shift, "R10 idle outputs",
              busy + done + mac_en + c_wr + home_shift, 0);
        check(cnt_comp == 0 && cnt_ovh == 0, "R10 counters zero", cnt_comp + cnt_ovh, 0);

        // ramp operands
        for (int i = 0; i < N; i++)
            for (int l = 0; l < N; l++) begin
                amat[i][l] = DW'(i*N + l + 1);
                bmat[i][l] = DW'(3*i + 5*l + 2);
            end
        run_one(1'b0);

        // top-of-range operands, fills the accumulator width
        for (int i = 0; i < N; i++)
            for (int l = 0; l < N; l++) begin
                amat[i][l] = '1;
                bmat[i][l] = '1;
            end
        run_one(1'b1);

        // pseudo-random operands, start poked mid-run
        begin
            int unsigned seed;
            seed = 32'h1234_5678;
            for (int i = 0; i < N; i++)
                for (int l = 0; l < N; l++) begin
                    seed = seed * 1664525 + 1013904223;
                    amat[i][l] = DW'(seed >> 13);
                    seed = seed * 1664525 + 1013904223;
                    bmat[i][l] = DW'(seed >> 11);
                end
        end
        run_one(1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule